// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a 10 Mb/s twisted-pair port has a working cable. It also produces the idle link pulses that the far end needs to see. On the receive side it takes a receive-data activity flag and two link-pulse detect strobes, one for each polarity. Each strobe is one clean clock cycle wide. From these it holds a link-good/link-fail status. On the transmit side it asks for a short positive link pulse at a fixed idle interval whenever no frame is being sent.

A good link falls to the failed state when a long silence passes with no receive data and no link pulse of either polarity. A failed link recovers only after an unbroken run of same-polarity pulses. The run is shorter for positive pulses than for negative ones. All intervals come from the `CLK_HZ` parameter, so one instance can serve any system clock. A one-cycle change strobe lets a host latch each status transition.

Top module: `tp_link_monitor`

## Requirements
- R1: During reset and in the first cycle after it, `linkGood`, `linkChanged` and `linkPulse` are 0, the link is in the failed state, and both run counts are empty.
- R2: With `txActive` low, `linkPulse` goes high for PULSE_CYC cycles once every IDLE_CYC cycles. IDLE_CYC = CLK_HZ*13/1000, which is 13 ms. PULSE_CYC = max(1, CLK_HZ/10_000_000), which is 100 ns.
- R3: Each cycle with `txActive` high restarts the idle interval. No pulse starts while `txActive` is high. The first pulse after the last cycle with `txActive` high comes exactly IDLE_CYC cycles later.
- R4: In link-good, if FAIL_CYC cycles pass after the last activity cycle with no activity, `linkGood` drops to 0 on the FAIL_CYC-th cycle. FAIL_CYC = CLK_HZ*105/1000, which is 105 ms. An activity cycle is one where `rxActive`, `posPulse` or `negPulse` is high.
- R5: In link-good, any single activity cycle on `rxActive`, `posPulse` or `negPulse` restarts the FAIL_CYC timeout.
- R6: From link-fail, four consecutive `posPulse` strobes set `linkGood` to 1 in the cycle after the fourth strobe. Three strobes are not enough.
- R7: From link-fail, eight consecutive `negPulse` strobes set `linkGood` to 1. Seven strobes are not enough.
- R8: In link-fail, a strobe of the opposite polarity empties the current run. The same happens when both polarities arrive in one cycle.
- R9: In link-fail, `rxActive` high empties both run counts.
- R10: `linkChanged` is high for exactly one cycle, in the same cycle that `linkGood` takes a new value, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txActive | input | 1 | A frame is being transmitted |
| rxActive | input | 1 | Receive data activity seen this cycle |
| posPulse | input | 1 | One-cycle strobe: positive link pulse detected |
| negPulse | input | 1 | One-cycle strobe: negative link pulse detected |
| linkPulse | output | 1 | Request to drive a positive idle link pulse |
| linkGood | output | 1 | 1 = link good, 0 = link failed |
| linkChanged | output | 1 | One-cycle strobe when linkGood changes |

## Verification
The hardest situation to reach is the silence timeout. It needs the link recovered first. It also needs a stretch of more than ten thousand cycles with every receive input quiet. Its edge must then be hit to the exact cycle.

The bench uses a scaled-down `CLK_HZ` to keep the run short. It recovers the link with pulse runs. It then places single activity strobes just before the timeout would expire, one for each kind of activity. Finally it counts cycles from the last strobe and samples `linkGood` one cycle before and at the expiry.

The run-clearing rules are reached by breaking partial runs with an opposite-polarity strobe or with receive data. A later full run must then be needed to recover.

// File: rtl/tplm_pkg.sv
package tplm_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic idleRestart;
    logic pulseStart;
    logic failRestart;
    logic runClear;
    logic posInc;
    logic negInc;
  } tplm_ctrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic idleDone;
    logic failDone;
    logic posHit;
    logic negHit;
  } tplm_stat_t;

endpackage

// File: rtl/tplm_datapath.sv
module tplm_datapath
  import tplm_pkg::*;
#(
  parameter int IDLE_CYC  = 130000,
  parameter int FAIL_CYC  = 1050000,
  parameter int PULSE_CYC = 1,
  parameter int POS_RUN   = 4,
  parameter int NEG_RUN   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tplm_ctrl_t ctrl,
  output tplm_stat_t stat,
  output logic       pulseActive
);

  localparam int IDLE_W  = $clog2(IDLE_CYC + 1);
  localparam int FAIL_W  = $clog2(FAIL_CYC + 1);
  localparam int PULSE_W = $clog2(PULSE_CYC + 1);
  localparam int MAXRUN  = (POS_RUN > NEG_RUN) ? POS_RUN : NEG_RUN;
  localparam int RUN_W   = $clog2(MAXRUN + 1);

  logic [IDLE_W-1:0]  idleCnt;
  logic [FAIL_W-1:0]  failCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic [RUN_W-1:0]   posCnt;
  logic [RUN_W-1:0]   negCnt;

  assign stat.idleDone = (idleCnt == IDLE_W'(IDLE_CYC - 1));
  assign stat.failDone = (failCnt == FAIL_W'(FAIL_CYC - 1));
  assign stat.posHit   = (posCnt == RUN_W'(POS_RUN - 1));
  assign stat.negHit   = (negCnt == RUN_W'(NEG_RUN - 1));
  assign pulseActive   = (pulseCnt != '0);

  // idle-pulse interval timer
  always_ff @(posedge clk) begin
    if (!rst_n)                              idleCnt <= '0;
    else if (ctrl.idleRestart || stat.idleDone) idleCnt <= '0;
    else                                     idleCnt <= idleCnt + 1'b1;
  end

  // pulse width counter
  always_ff @(posedge clk) begin
    if (!rst_n)               pulseCnt <= '0;
    else if (ctrl.pulseStart) pulseCnt <= PULSE_W'(PULSE_CYC);
    else if (pulseActive)     pulseCnt <= pulseCnt - 1'b1;
  end

  // silence timeout, saturating at its terminal count
  always_ff @(posedge clk) begin
    if (!rst_n)                failCnt <= '0;
    else if (ctrl.failRestart) failCnt <= '0;
    else if (!stat.failDone)   failCnt <= failCnt + 1'b1;
  end

  // consecutive-pulse run counters
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.runClear) begin
      posCnt <= '0;
      negCnt <= '0;
    end else if (ctrl.posInc) begin
      posCnt <= posCnt + 1'b1;
      negCnt <= '0;
    end else if (ctrl.negInc) begin
      negCnt <= negCnt + 1'b1;
      posCnt <= '0;
    end
  end

endmodule

// File: rtl/tplm_control.sv
module tplm_control
  import tplm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txActive,
  input  logic       rxActive,
  input  logic       posPulse,
  input  logic       negPulse,
  input  tplm_stat_t stat,
  output tplm_ctrl_t ctrl,
  output logic       linkGood,
  output logic       linkChanged
);

  typedef enum logic {LINK_FAIL = 1'b0, LINK_GOOD = 1'b1} link_state_e;

  link_state_e state, stateNext;
  logic        activity;

  assign activity = rxActive | posPulse | negPulse;

  always_comb begin
    stateNext        = state;
    ctrl             = '0;
    ctrl.idleRestart = txActive;
    ctrl.pulseStart  = stat.idleDone && !txActive;
    ctrl.failRestart = activity;
    unique case (state)
      LINK_GOOD: begin
        if (!activity && stat.failDone) begin
          stateNext     = LINK_FAIL;
          ctrl.runClear = 1'b1;
        end
      end
      LINK_FAIL: begin
        if (rxActive || (posPulse && negPulse)) begin
          ctrl.runClear = 1'b1;
        end else if (posPulse) begin
          if (stat.posHit) begin
            stateNext     = LINK_GOOD;
            ctrl.runClear = 1'b1;
          end else begin
            ctrl.posInc = 1'b1;
          end
        end else if (negPulse) begin
          if (stat.negHit) begin
            stateNext     = LINK_GOOD;
            ctrl.runClear = 1'b1;
          end else begin
            ctrl.negInc = 1'b1;
          end
        end
      end
      default: stateNext = LINK_FAIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= LINK_FAIL;
      linkChanged <= 1'b0;
    end else begin
      state       <= stateNext;
      linkChanged <= (stateNext != state);
    end
  end

  assign linkGood = (state == LINK_GOOD);

endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import tplm_pkg::*;
#(
  parameter int CLK_HZ  = 10_000_000,
  parameter int POS_RUN = 4,
  parameter int NEG_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txActive,
  input  logic rxActive,
  input  logic posPulse,
  input  logic negPulse,
  output logic linkPulse,
  output logic linkGood,
  output logic linkChanged
);

  localparam longint IDLE_L  = (longint'(CLK_HZ) * 13) / 1000;
  localparam longint FAIL_L  = (longint'(CLK_HZ) * 105) / 1000;
  localparam longint PULSE_L = longint'(CLK_HZ) / 10_000_000;
  localparam int IDLE_CYC  = int'(IDLE_L);
  localparam int FAIL_CYC  = int'(FAIL_L);
  localparam int PULSE_CYC = (PULSE_L < 1) ? 1 : int'(PULSE_L);

  tplm_ctrl_t ctrl;
  tplm_stat_t stat;

  tplm_control ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .txActive   (txActive),
    .rxActive   (rxActive),
    .posPulse   (posPulse),
    .negPulse   (negPulse),
    .stat       (stat),
    .ctrl       (ctrl),
    .linkGood   (linkGood),
    .linkChanged(linkChanged)
  );

  tplm_datapath #(
    .IDLE_CYC (IDLE_CYC),
    .FAIL_CYC (FAIL_CYC),
    .PULSE_CYC(PULSE_CYC),
    .POS_RUN  (POS_RUN),
    .NEG_RUN  (NEG_RUN)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .stat       (stat),
    .pulseActive(linkPulse)
  );

endmodule

// File: rtl/tp_link_monitor_chk.sv
module tp_link_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic txActive,
  input logic rxActive,
  input logic posPulse,
  input logic negPulse,
  input logic linkPulse,
  input logic linkGood,
  input logic linkChanged
);

  // R3
  pulse_not_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkPulse) |-> !$past(txActive));

  // R10
  changed_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkChanged == (linkGood != $past(linkGood)));

  // R6
  recover_by_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkGood) |-> ($past(posPulse) || $past(negPulse)) && !$past(rxActive));

  // R4
  fail_only_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(linkGood) |-> !$past(rxActive || posPulse || negPulse));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> !linkGood && !linkChanged && !linkPulse);

endmodule

bind tp_link_monitor tp_link_monitor_chk chk_i (.*);

// File: tb/tp_link_monitor_tb.sv
module tp_link_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 100_000;
  localparam int IDLE_CYC   = CLK_HZ * 13 / 1000;
  localparam int FAIL_CYC   = CLK_HZ * 105 / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txActive = 1'b0, rxActive = 1'b0, posPulse = 1'b0, negPulse = 1'b0;
  logic linkPulse, linkGood, linkChanged;
  logic lastChg;
  int   nTests = 0;
  int   nFail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_link_monitor #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .txActive(txActive), .rxActive(rxActive),
    .posPulse(posPulse), .negPulse(negPulse),
    .linkPulse(linkPulse), .linkGood(linkGood), .linkChanged(linkChanged)
  );

  task automatic check(string req, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 pos, 1 neg, 2 rx, 3 both polarities
  task automatic strobe(int kind);
    posPulse = (kind == 0 || kind == 3);
    negPulse = (kind == 1 || kind == 3);
    rxActive = (kind == 2);
    @(negedge clk);
    lastChg  = linkChanged;
    posPulse = 1'b0; negPulse = 1'b0; rxActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "linkGood in reset", linkGood, 0);
    check("R1", "linkPulse in reset", linkPulse, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "linkGood after reset", linkGood, 0);
    check("R1", "linkChanged after reset", linkChanged, 0);
  endtask

  task automatic t_idle_period();
    int gap;
    int guard = 0;
    while (!linkPulse && guard < 3 * IDLE_CYC) begin @(negedge clk); guard++; end
    check("R2", "first idle pulse seen", linkPulse, 1);
    @(negedge clk);
    check("R2", "pulse width one cycle", linkPulse, 0);
    gap = 1;
    while (!linkPulse && gap < 3 * IDLE_CYC) begin @(negedge clk); gap++; end
    check("R2", "idle pulse period", gap, IDLE_CYC);
  endtask

  task automatic t_tx_hold();
    int seen = 0;
    int gap  = 0;
    // now just after a pulse start; hold tx beyond one interval
    txActive = 1'b1;
    for (int i = 0; i < 2 * IDLE_CYC; i++) begin
      @(negedge clk);
      if (i > 1 && linkPulse) seen++;
    end
    check("R3", "pulses during tx", seen, 0);
    txActive = 1'b0;
    while (!linkPulse && gap < 3 * IDLE_CYC) begin @(negedge clk); gap++; end
    check("R3", "first pulse after tx ends", gap, IDLE_CYC);
  endtask

  task automatic t_recover_pos();
    for (int i = 0; i < 3; i++) strobe(0);
    strobe(1); // R8 opposite polarity clears run
    for (int i = 0; i < 3; i++) strobe(0);
    check("R8", "fail after broken pos run", linkGood, 0);
    strobe(3); // R8 both polarities together clear
    for (int i = 0; i < 3; i++) strobe(0);
    check("R8", "fail after dual strobe break", linkGood, 0);
    check("R6", "fail after three pos", linkGood, 0);
    strobe(0);
    check("R6", "good after fourth pos", linkGood, 1);
    check("R10", "changed on rise", lastChg, 1);
    check("R10", "changed drops", linkChanged, 0);
  endtask

  task automatic t_keep_alive();
    for (int k = 0; k < 3; k++) begin
      wait_cyc(FAIL_CYC - 20);
      strobe(k == 0 ? 2 : (k == 1 ? 0 : 1));
      check("R5", "still good after activity", linkGood, 1);
    end
  endtask

  task automatic t_timeout();
    // last activity was sampled one edge before the current negedge minus one
    strobe(2);
    // after strobe: one more edge passed since the sampled edge
    wait_cyc(FAIL_CYC - 2);
    check("R4", "good just before timeout", linkGood, 1);
    @(negedge clk);
    check("R4", "fail at timeout", linkGood, 0);
    check("R10", "changed on fall", linkChanged, 1);
    @(negedge clk);
    check("R10", "changed one cycle", linkChanged, 0);
  endtask

  task automatic t_recover_neg();
    for (int i = 0; i < 7; i++) strobe(1);
    strobe(2); // R9 receive data clears run
    for (int i = 0; i < 7; i++) strobe(1);
    check("R9", "fail after rx broke run", linkGood, 0);
    check("R7", "fail after seven neg", linkGood, 0);
    strobe(1);
    check("R7", "good after eighth neg", linkGood, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle_period();
        t_tx_hold();
        t_recover_pos();
        t_keep_alive();
        t_timeout();
        t_recover_neg();
      end
      begin
        repeat (190_000) @(negedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule